// File: doc/BRIEF.md
# BF16 Pair Dot-Product Accumulate Lane

This block is one 32-bit lane of a bfloat16 dot-product unit. Each operation takes a single-precision accumulator and two 32-bit operands. Each operand packs two bfloat16 values. The lane forms the product of the two upper halves and adds it to the accumulator with one rounding. It then forms the product of the two lower halves and adds that to the intermediate sum with a second rounding. The result is a single-precision value.

One combinational multiply-add datapath is shared by both steps. A pulse on `start` while the lane is idle captures the operands and performs the first step on that clock edge. The second step is performed on the following edge. On that edge `result` is loaded and `done` pulses for one cycle.

Rounding is always round-to-nearest-even. Subnormals are treated as zero on input and flushed to zero on output. NaN inputs are resolved by a fixed priority, so the lane gives the same answer whatever the order of the two steps. No status flags are produced.

Top module: `bf16_dot_lane`

## Requirements
- R1: A `start` sampled high while `busy` is low is accepted. `busy` is high for exactly the next cycle and `done` is high for exactly the cycle after that. A `start` sampled while `busy` is high is ignored.
- R2: A bfloat16 value is widened by placing it in bits 31:16 of a single-precision word with zeros below. The upper pair (bits 31:16 of both operands) is accumulated first and the lower pair (bits 15:0) second. Each step is a fused multiply-add with a single round-to-nearest-even.
- R3: A subnormal accumulator or bfloat16 input (exponent field 0) is used as a zero of the same sign.
- R4: A step result whose magnitude after rounding is below 2^-126 becomes a zero of the same sign. This applies to both the intermediate and the final value. Rounding is done as if the exponent range were unbounded.
- R5: If any input is NaN, the result is that NaN widened and quieted (bit 22 set). The NaN is picked in this order: `a_in[15:0]`, `b_in[15:0]`, `a_in[31:16]`, `b_in[31:16]`, `acc_in`.
- R6: The accumulator NaN reaches the result only when none of the four bfloat16 inputs is NaN.
- R7: Infinity times zero, and the sum of opposite-signed infinities, produce 0x7FC00000.
- R8: A finite result whose rounded magnitude reaches 2^128 becomes an infinity of the result's sign.
- R9: An exact zero sum of nonzero opposite-signed terms gives +0. A sum of two zeros gives -0 only when both zeros are negative.
- R10: `result` changes only on the edge that raises `done`, and holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation (accepted when idle) |
| acc_in | input | 32 | Single-precision accumulator |
| a_in | input | 32 | First operand, two bfloat16 values |
| b_in | input | 32 | Second operand, two bfloat16 values |
| busy | output | 1 | High during the second step |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 32 | Single-precision result |

## Verification
A wrong intermediate register, such as a badly rounded or unflushed first step, shows in `result` on the `done` pulse of that same operation. The directed cases are chosen so that a single fused rounding, or a reversed step order, gives a different bit pattern from the correct two-step answer. A stale NaN-capture flag or payload gives a wrong NaN or a wrongly overridden number on the very next completion. A handshake fault shows one cycle after the offending `start`, as a missing `done` or a `result` that moves without `done`.

// File: rtl/bf16_dot_lane.sv
module bf16_dot_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] acc_in,
  input  logic [31:0] a_in,
  input  logic [31:0] b_in,
  output logic        busy,
  output logic        done,
  output logic [31:0] result
);
  localparam logic [31:0] QNAN = 32'h7FC0_0000;
  localparam logic [31:0] QBIT = 32'h0040_0000;
  localparam int EXT = 27;
  localparam int SW  = 1 + 24 + EXT;

  logic [31:0] mid_q, nan_q;
  logic [15:0] alo_q, blo_q;
  logic        nan_hit_q;

  logic [31:0] fc;
  logic [15:0] fa, fb;
  assign fc = busy ? mid_q : acc_in;
  assign fa = busy ? alo_q : a_in[31:16];
  assign fb = busy ? blo_q : b_in[31:16];

  logic a_zero, a_inf, a_nan, b_zero, b_inf, b_nan, c_zero, c_inf, c_nan;
  assign a_zero = (fa[14:7] == 8'h00);
  assign a_inf  = (&fa[14:7]) & ~|fa[6:0];
  assign a_nan  = (&fa[14:7]) &  |fa[6:0];
  assign b_zero = (fb[14:7] == 8'h00);
  assign b_inf  = (&fb[14:7]) & ~|fb[6:0];
  assign b_nan  = (&fb[14:7]) &  |fb[6:0];
  assign c_zero = (fc[30:23] == 8'h00);
  assign c_inf  = (&fc[30:23]) & ~|fc[22:0];
  assign c_nan  = (&fc[30:23]) &  |fc[22:0];

  logic sp, sc;
  assign sp = fa[15] ^ fb[15];
  assign sc = fc[31];

  logic [15:0] prod;
  assign prod = {1'b1, fa[6:0]} * {1'b1, fb[6:0]};

  logic signed [11:0] ep, ecx, e_big, e_sml, diff;
  assign ep  = $signed({4'b0, fa[14:7]}) + $signed({4'b0, fb[14:7]}) - 12'sd276;
  assign ecx = c_zero ? -12'sd1024 : $signed({4'b0, fc[30:23]}) - 12'sd150;

  logic        p_big;
  logic [23:0] sig_p, sig_c, big_sig, sml_sig;
  assign p_big   = (ep >= ecx);
  assign sig_p   = {prod, 8'h00};
  assign sig_c   = c_zero ? 24'h0 : {1'b1, fc[22:0]};
  assign big_sig = p_big ? sig_p : sig_c;
  assign sml_sig = p_big ? sig_c : sig_p;
  assign e_big   = p_big ? ep : ecx;
  assign e_sml   = p_big ? ecx : ep;
  assign diff    = e_big - e_sml;

  logic [6:0]      shamt;
  logic [SW+63:0]  wide, shifted;
  logic [SW-1:0]   aln_b, aln_s, sum;
  assign shamt   = (diff > 12'sd64) ? 7'd64 : diff[6:0];
  assign wide    = {1'b0, sml_sig, {EXT{1'b0}}, 64'h0};
  assign shifted = wide >> shamt;
  assign aln_s   = shifted[SW+63:64] | {{(SW-1){1'b0}}, |shifted[63:0]};
  assign aln_b   = {1'b0, big_sig, {EXT{1'b0}}};

  logic sgn;
  always_comb begin
    if (sp == sc) begin
      sum = aln_b + aln_s;
      sgn = sp;
    end else if (aln_b >= aln_s) begin
      sum = aln_b - aln_s;
      sgn = p_big ? sp : sc;
    end else begin
      sum = aln_s - aln_b;
      sgn = p_big ? sc : sp;
    end
  end

  logic [5:0] lz;
  always_comb begin
    lz = 6'd0;
    for (int i = 0; i < SW; i++)
      if (sum[i]) lz = i[5:0];
  end

  logic [SW-1:0]      norm;
  logic               rnd;
  logic [24:0]        sig25;
  logic signed [11:0] be;
  logic [22:0]        frac;
  assign norm  = sum << (6'd51 - lz);
  assign rnd   = norm[EXT] & ((|norm[EXT-1:0]) | norm[EXT+1]);
  assign sig25 = {1'b0, norm[SW-1:EXT+1]} + {24'h0, rnd};
  assign be    = $signed({6'b0, lz}) + e_big + 12'sd100 + $signed({11'b0, sig25[24]});
  assign frac  = sig25[24] ? sig25[23:1] : sig25[22:0];

  logic [31:0] gen_out, fma_out;
  always_comb begin
    if (sum == '0)            gen_out = 32'h0000_0000;
    else if (be >= 12'sd255)  gen_out = {sgn, 8'hFF, 23'h0};
    else if (be <= 12'sd0)    gen_out = {sgn, 31'h0};
    else                      gen_out = {sgn, be[7:0], frac};
  end

  always_comb begin
    if (a_nan)                                  fma_out = {fa, 16'h0} | QBIT;
    else if (b_nan)                             fma_out = {fb, 16'h0} | QBIT;
    else if (c_nan)                             fma_out = fc | QBIT;
    else if ((a_inf & b_zero) | (b_inf & a_zero)) fma_out = QNAN;
    else if (a_inf | b_inf)                     fma_out = (c_inf & (sc != sp)) ? QNAN : {sp, 8'hFF, 23'h0};
    else if (c_inf)                             fma_out = fc;
    else if (a_zero | b_zero)                   fma_out = c_zero ? {sc & sp, 31'h0} : fc;
    else                                        fma_out = gen_out;
  end

  function automatic logic is_nan16(input logic [15:0] x);
    return (&x[14:7]) & (|x[6:0]);
  endfunction

  logic        nan_any;
  logic [31:0] nan_pick;
  always_comb begin
    nan_any = 1'b1;
    if (is_nan16(a_in[15:0]))       nan_pick = {a_in[15:0], 16'h0} | QBIT;
    else if (is_nan16(b_in[15:0]))  nan_pick = {b_in[15:0], 16'h0} | QBIT;
    else if (is_nan16(a_in[31:16])) nan_pick = {a_in[31:16], 16'h0} | QBIT;
    else if (is_nan16(b_in[31:16])) nan_pick = {b_in[31:16], 16'h0} | QBIT;
    else if ((&acc_in[30:23]) & (|acc_in[22:0])) nan_pick = acc_in | QBIT;
    else begin
      nan_pick = 32'h0;
      nan_any  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      result    <= 32'h0;
      mid_q     <= 32'h0;
      alo_q     <= 16'h0;
      blo_q     <= 16'h0;
      nan_hit_q <= 1'b0;
      nan_q     <= 32'h0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        result <= nan_hit_q ? nan_q : fma_out;
        done   <= 1'b1;
        busy   <= 1'b0;
      end else if (start) begin
        mid_q     <= fma_out;
        alo_q     <= a_in[15:0];
        blo_q     <= b_in[15:0];
        nan_hit_q <= nan_any;
        nan_q     <= nan_pick;
        busy      <= 1'b1;
      end
    end
  end
endmodule

module bf16_dot_lane_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] result
);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R1
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy));
  // R1
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R4
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[30:23] != 8'h00 || result[22:0] == 23'h0));
  // R5
  quiet_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (&result[30:23]) && (|result[22:0])) |-> result[22]);
endmodule

bind bf16_dot_lane bf16_dot_lane_chk u_chk (.*);

// File: tb/sim_bf16_dot_lane.sv
`timescale 1ns/1ps
module sim_bf16_dot_lane;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] acc_in = '0, a_in = '0, b_in = '0;
  logic busy, done;
  logic [31:0] result;
  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bf16_dot_lane u0 (.clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in),
                    .a_in(a_in), .b_in(b_in), .busy(busy), .done(done), .result(result));

  localparam logic [31:0] QN = 32'h7FC0_0000;

  function automatic bit nan16(input logic [15:0] x);
    return (&x[14:7]) && (|x[6:0]);
  endfunction
  function automatic bit nan32(input logic [31:0] x);
    return (&x[30:23]) && (|x[22:0]);
  endfunction

  function automatic real to_real(input logic [31:0] x);
    logic [63:0] d;
    if (x[30:23] == 8'h0) d = {x[31], 63'h0};
    else d = {x[31], {3'b0, x[30:23]} + 11'd896, x[22:0], 29'h0};
    return $bitstoreal(d);
  endfunction

  function automatic logic [31:0] to_f32(input real v);
    logic [63:0] d;
    logic [24:0] s;
    int e;
    d = $realtobits(v);
    if (d[62:52] == 11'h0) return {d[63], 31'h0};
    e = int'(d[62:52]) - 1023;
    s = {2'b01, d[51:29]};
    if (d[28] && ((|d[27:0]) || d[29])) s = s + 25'd1;
    if (s[24]) e = e + 1;
    if (e + 127 >= 255) return {d[63], 8'hFF, 23'h0};
    if (e + 127 <= 0) return {d[63], 31'h0};
    return {d[63], 8'(e + 127), s[22:0]};
  endfunction

  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [15:0] a, input logic [15:0] b);
    bit ainf, binf, az, bz, cinf, sp;
    if (c[30:23] == 8'h0) c = {c[31], 31'h0};
    if (a[14:7] == 8'h0) a = {a[15], 15'h0};
    if (b[14:7] == 8'h0) b = {b[15], 15'h0};
    if (nan16(a)) return {a, 16'h0} | 32'h0040_0000;
    if (nan16(b)) return {b, 16'h0} | 32'h0040_0000;
    if (nan32(c)) return c | 32'h0040_0000;
    ainf = (a[14:0] == 15'h7F80);
    binf = (b[14:0] == 15'h7F80);
    az = (a[14:0] == 15'h0);
    bz = (b[14:0] == 15'h0);
    cinf = (c[30:0] == 31'h7F80_0000);
    sp = a[15] ^ b[15];
    if ((ainf && bz) || (binf && az)) return QN;
    if (ainf || binf) return (cinf && (c[31] != sp)) ? QN : {sp, 8'hFF, 23'h0};
    if (cinf) return c;
    return to_f32(to_real(c) + to_real({a, 16'h0}) * to_real({b, 16'h0}));
  endfunction

  function automatic logic [31:0] ref_full(input logic [31:0] c, input logic [31:0] a, input logic [31:0] b);
    if (nan16(a[15:0]))  return {a[15:0], 16'h0} | 32'h0040_0000;
    if (nan16(b[15:0]))  return {b[15:0], 16'h0} | 32'h0040_0000;
    if (nan16(a[31:16])) return {a[31:16], 16'h0} | 32'h0040_0000;
    if (nan16(b[31:16])) return {b[31:16], 16'h0} | 32'h0040_0000;
    if (nan32(c))        return c | 32'h0040_0000;
    return ref_step(ref_step(c, a[31:16], b[31:16]), a[15:0], b[15:0]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] c, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    acc_in = c; a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check({req, " done"}, {31'h0, done}, 32'h1);
    check(req, result, ref_full(c, a, b));
  endtask

  task automatic run_fixed(input string req, input logic [31:0] c, input logic [31:0] a,
                           input logic [31:0] b, input logic [31:0] exp);
    run_op(req, c, a, b);
    check({req, " fixed"}, result, exp);
  endtask

  function automatic logic [15:0] rnd_bf16();
    int r;
    logic s;
    r = $urandom_range(0, 63);
    s = 1'($urandom);
    if (r == 0) return {s, 15'h0};
    if (r == 1) return {s, 8'hFF, 7'h0};
    if (r == 2) return {s, 8'hFF, 7'($urandom) | 7'h1};
    if (r == 3) return {s, 8'h00, 7'($urandom)};
    if (r < 40) return {s, 8'($urandom_range(110, 144)), 7'($urandom)};
    return {s, 8'($urandom_range(1, 254)), 7'($urandom)};
  endfunction

  function automatic logic [31:0] rnd_f32();
    int r;
    logic s;
    r = $urandom_range(0, 63);
    s = 1'($urandom);
    if (r == 0) return {s, 31'h0};
    if (r == 1) return {s, 8'hFF, 23'h0};
    if (r == 2) return {s, 8'hFF, 23'($urandom) | 23'h1};
    if (r == 3) return {s, 8'h00, 23'($urandom)};
    if (r < 40) return {s, 8'($urandom_range(110, 150)), 23'($urandom)};
    return {s, 8'($urandom_range(1, 254)), 23'($urandom)};
  endfunction

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset busy", {31'h0, busy}, 32'h0);
    check("R1 reset done", {31'h0, done}, 32'h0);
    check("R10 reset result", result, 32'h0);
    rst_n = 1'b1;

    run_fixed("R2 basic", 32'h3F80_0000, 32'h3F80_3F80, 32'h3F80_3F80, 32'h4040_0000);
    run_fixed("R2 two ties", 32'h3F80_0000, 32'h3980_3980, 32'h3980_3980, 32'h3F80_0000);
    run_fixed("R2 order", 32'h3F80_0000, 32'hBF80_3980, 32'h3F80_3980, 32'h3380_0000);
    run_fixed("R3 sub acc", 32'h007F_FFFF, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000);
    run_fixed("R3 sub bf16", 32'h3F80_0000, 32'h0040_0000, 32'h7F00_0000, 32'h3F80_0000);
    run_fixed("R4 mid flush", 32'h0000_0000, 32'h9C80_9C80, 32'h1C80_1C80, 32'h8000_0000);
    run_fixed("R4 final flush", 32'h0080_0000, 32'h0000_BF00, 32'h0000_0080, 32'h0000_0000);
    run_fixed("R5 low a", 32'h7F80_0005, 32'h7F81_7F82, 32'hFF83_7F84, 32'h7FC2_0000);
    run_fixed("R5 low b", 32'h7F80_0005, 32'h7F81_3F80, 32'hFF83_7F84, 32'h7FC4_0000);
    run_fixed("R5 high a", 32'h7F80_0005, 32'h7F81_3F80, 32'hFF83_3F80, 32'h7FC1_0000);
    run_fixed("R5 high b", 32'h7F80_0005, 32'h3F80_3F80, 32'hFF83_3F80, 32'hFFC3_0000);
    run_fixed("R6 acc nan", 32'h7F80_0005, 32'h3F80_3F80, 32'h3F80_3F80, 32'h7FC0_0005);
    run_fixed("R6 bf16 wins", 32'hFFC0_1234, 32'h3F80_3F80, 32'h7FA0_3F80, 32'h7FE0_0000);
    run_fixed("R7 inf x 0", 32'h3F80_0000, 32'h7F80_3F80, 32'h0000_3F80, QN);
    run_fixed("R7 inf - inf", 32'hFF80_0000, 32'h7F80_0000, 32'h3F80_0000, QN);
    run_fixed("R8 overflow pos", 32'h7F7F_FFFF, 32'h7F00_0000, 32'h3F80_0000, 32'h7F80_0000);
    run_fixed("R8 overflow neg", 32'hFF7F_FFFF, 32'hFF00_0000, 32'h3F80_0000, 32'hFF80_0000);
    run_fixed("R9 cancel", 32'h4040_0000, 32'hBF80_0000, 32'h4040_0000, 32'h0000_0000);
    run_fixed("R9 neg zeros", 32'h8000_0000, 32'h8000_8000, 32'h3F80_3F80, 32'h8000_0000);

    // R1 / R10: a second start while busy is ignored, result then holds
    @(negedge clk);
    acc_in = 32'h3F80_0000; a_in = 32'h4000_4000; b_in = 32'h4000_4000; start = 1'b1;
    @(negedge clk);
    check("R1 busy after accept", {31'h0, busy}, 32'h1);
    check("R1 no early done", {31'h0, done}, 32'h0);
    acc_in = 32'h4000_0000; a_in = 32'h3F80_3F80; b_in = 32'hC000_C000;
    @(negedge clk);
    start = 1'b0;
    check("R1 done", {31'h0, done}, 32'h1);
    check("R1 first op kept", result, 32'h4110_0000);
    held = result;
    @(negedge clk);
    check("R1 ignored start", {31'h0, done | busy}, 32'h0);
    check("R10 hold", result, held);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ra, rb, rc;
      ra = {rnd_bf16(), rnd_bf16()};
      rb = {rnd_bf16(), rnd_bf16()};
      rc = rnd_f32();
      if ($urandom_range(0, 7) == 0) rc = ref_step(32'h0, ra[31:16] ^ 16'h8000, rb[31:16]);
      run_op("R2 random", rc, ra, rb);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule